// File: doc/BRIEF.md
# In-Frame Response Arbitration Controller

This block decides how one node takes part in the response section of a frame, after the end-of-data point. When the host has asked for a response, the controller starts the normal-bit symbol once end-of-data is seen. It then sends the response bytes through an arbitrating symbol transmitter. It watches that transmitter's loss indication and chooses, byte by byte, whether to continue, give up, or try again.

Three frame kinds are handled. For kinds 1 and 3 the node arbitrates once. A loser aborts and stays silent until end-of-frame, and a winner sends its whole response. For kind 2 a loser tries again at the next byte boundary seen on the bus. A winner stops after one byte and listens until end-of-frame. A break aborts any activity at once. When no response is requested, the controller stays idle and does nothing.

The transmitter drives symbols onto the bus. The controller only issues start, byte and abort commands to it, and it takes the symbol-finished and arbitration-lost pulses back.

Top module: `ifr_arb_ctrl`

## Requirements
- R1: The controller stays idle (busy low, no commands) through end-of-data and end-of-frame when `rsp_enable` is low, `frame_kind` is 2'd0, `rsp_count` is 0, or `rsp_count` exceeds the byte capacity.
- R2: An end-of-data pulse with a valid request gives a one-cycle `nb_go` on the next cycle. `nb_long` is 1 for kinds 2'd1 and 2'd2 and 0 for kind 2'd3.
- R3: A `sym_done` that finishes the normal-bit symbol gives a one-cycle `byte_go` on the next cycle. At that point `byte_out` holds byte 0, which is `rsp_bytes[7:0]`. Byte i is `rsp_bytes[8*i+7:8*i]`.
- R4: For kinds 1 and 3, each `sym_done` after a byte loads the next byte until `rsp_count` bytes have gone. After the last byte, `responded` rises and no further byte is sent.
- R5: For kinds 1 and 3, `arb_lost` during the normal-bit symbol or a byte gives a one-cycle `tx_abort`. After that, neither byte boundaries nor `sym_done` cause another `byte_go` before end-of-frame.
- R6: For kind 2, `arb_lost` gives a one-cycle `tx_abort`. The next `byte_edge` then reloads byte 0 with a `byte_go`.
- R7: For kind 2, the first byte that completes without loss raises `responded`. Later `byte_edge` pulses in that frame cause no `byte_go`.
- R8: `brk_pulse` returns the controller to idle on the next cycle and clears `responded`. It gives a `tx_abort` only when the normal-bit symbol or a byte was in flight.
- R9: `eof_pulse` returns the controller to idle. `responded` holds its value until the next end-of-data or break.
- R10: When `arb_lost` and `sym_done` arrive in the same cycle, the loss takes effect: `tx_abort` pulses, no byte is credited and no next byte is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eod_pulse | input | 1 | End-of-data seen on the bus |
| eof_pulse | input | 1 | End-of-frame seen on the bus |
| brk_pulse | input | 1 | Break symbol received |
| byte_edge | input | 1 | Byte boundary seen on the bus |
| rsp_enable | input | 1 | Host requests a response in this frame |
| frame_kind | input | 2 | Frame kind: 1, 2 or 3; 0 means none |
| rsp_count | input | CW | Number of response bytes |
| rsp_bytes | input | 8*MAXB | Response bytes, byte i at bits 8i+7..8i |
| sym_done | input | 1 | Transmitter finished current symbol or byte |
| arb_lost | input | 1 | Transmitter lost arbitration |
| nb_go | output | 1 | Start normal-bit symbol |
| nb_long | output | 1 | Normal-bit symbol uses the long active pulse |
| byte_go | output | 1 | Load `byte_out` into the transmitter |
| byte_out | output | 8 | Byte to transmit |
| tx_abort | output | 1 | Relinquish the bus |
| responded | output | 1 | This node's response completed |
| busy | output | 1 | Controller is active in this frame |

## Verification
Two of the controller's functions can fall in the same cycle. The first is crediting a finished byte on `sym_done`, and the second is giving up on `arb_lost`. Both can also clash with a break arriving mid-byte. The bench drives `sym_done` and `arb_lost` together on the only byte of a kind-1 response. It judges the outcome as a loss: an abort pulse, `responded` staying low, and no byte loaded. It also drives a break while a byte is in flight, and it expects an abort followed by idle with the completion flag cleared.

// File: rtl/ifr_arb_pkg.sv
package ifr_arb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_NB     = 3'd1,
      ST_SEND   = 3'd2,
      ST_RETRY  = 3'd3,
      ST_LISTEN = 3'd4
   } ifr_state_t;

   localparam logic [1:0] KIND_NONE = 2'd0;
   localparam logic [1:0] KIND_ONE  = 2'd1;
   localparam logic [1:0] KIND_TWO  = 2'd2;
   localparam logic [1:0] KIND_THREE = 2'd3;

   typedef struct packed {
      logic valid;
      logic nb_long;
      logic one_byte;
   } ifr_policy_t;

endpackage

// File: rtl/ifr_policy.sv
module ifr_policy
   import ifr_arb_pkg::*;
#(
   parameter int MAXB = 8,
   localparam int CW  = $clog2(MAXB + 1)
)(
   input  logic          enable,
   input  logic [1:0]    kind,
   input  logic [CW-1:0] count,
   output ifr_policy_t   pol
);

   logic count_ok;

   always_comb begin
      count_ok     = (count != '0) && (32'(count) <= MAXB);
      pol.valid    = enable && (kind != KIND_NONE) && count_ok;
      pol.nb_long  = (kind != KIND_THREE);
      pol.one_byte = (kind == KIND_TWO);
   end

endmodule

// File: rtl/ifr_byte_sel.sv
module ifr_byte_sel #(
   parameter int MAXB       = 8,
   parameter bit AND_OR_MUX = 1'b1,
   localparam int IW        = $clog2(MAXB)
)(
   input  logic [8*MAXB-1:0] bytes,
   input  logic [IW-1:0]     idx,
   output logic [7:0]        sel
);

   logic [7:0] lanes [MAXB];

   for (genvar g = 0; g < MAXB; g++) begin : g_lane
      assign lanes[g] = bytes[8*g +: 8];
   end

   if (AND_OR_MUX) begin : g_andor
      always_comb begin
         sel = '0;
         for (int i = 0; i < MAXB; i++) begin
            sel = sel | (lanes[i] & {8{idx == IW'(i)}});
         end
      end
   end else begin : g_index
      always_comb begin
         sel = '0;
         if (32'(idx) < MAXB) sel = lanes[idx];
      end
   end

endmodule

// File: rtl/ifr_fsm.sv
module ifr_fsm
   import ifr_arb_pkg::*;
#(
   parameter int MAXB = 8,
   localparam int IW  = $clog2(MAXB),
   localparam int CW  = $clog2(MAXB + 1)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          eod_pulse,
   input  logic          eof_pulse,
   input  logic          brk_pulse,
   input  logic          byte_edge,
   input  logic          sym_done,
   input  logic          arb_lost,
   input  ifr_policy_t   pol,
   input  logic [CW-1:0] count,
   input  logic [7:0]    sel_byte,
   output logic [IW-1:0] sel_idx,
   output logic          nb_go,
   output logic          nb_long,
   output logic          byte_go,
   output logic [7:0]    byte_out,
   output logic          tx_abort,
   output logic          responded,
   output logic          busy
);

   ifr_state_t    state;
   logic [IW-1:0] idx;
   logic [IW-1:0] last_idx;
   logic          one_byte_q;
   logic          in_flight;
   logic          at_last;

   always_comb begin
      in_flight = (state == ST_NB) || (state == ST_SEND);
      at_last   = one_byte_q || (idx == last_idx);
      sel_idx   = (state == ST_SEND) ? IW'(idx + 1'b1) : '0;
      busy      = (state != ST_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         idx        <= '0;
         last_idx   <= '0;
         one_byte_q <= 1'b0;
         nb_go      <= 1'b0;
         nb_long    <= 1'b0;
         byte_go    <= 1'b0;
         byte_out   <= '0;
         tx_abort   <= 1'b0;
         responded  <= 1'b0;
      end else begin
         nb_go    <= 1'b0;
         byte_go  <= 1'b0;
         tx_abort <= 1'b0;
         if (brk_pulse) begin
            tx_abort  <= in_flight;
            responded <= 1'b0;
            state     <= ST_IDLE;
         end else begin
            unique case (state)
               ST_IDLE: begin
                  if (eod_pulse) begin
                     responded <= 1'b0;
                     if (pol.valid) begin
                        state      <= ST_NB;
                        nb_go      <= 1'b1;
                        nb_long    <= pol.nb_long;
                        one_byte_q <= pol.one_byte;
                        last_idx   <= IW'(count - 1'b1);
                        idx        <= '0;
                     end
                  end
               end
               ST_NB, ST_SEND: begin
                  if (eof_pulse) begin
                     tx_abort <= 1'b1;
                     state    <= ST_IDLE;
                  end else if (arb_lost) begin
                     tx_abort <= 1'b1;
                     state    <= one_byte_q ? ST_RETRY : ST_LISTEN;
                  end else if (sym_done) begin
                     if (state == ST_NB) begin
                        byte_go  <= 1'b1;
                        byte_out <= sel_byte;
                        idx      <= '0;
                        state    <= ST_SEND;
                     end else if (at_last) begin
                        responded <= 1'b1;
                        state     <= ST_LISTEN;
                     end else begin
                        byte_go  <= 1'b1;
                        byte_out <= sel_byte;
                        idx      <= sel_idx;
                     end
                  end
               end
               ST_RETRY: begin
                  if (eof_pulse) begin
                     state <= ST_IDLE;
                  end else if (byte_edge) begin
                     byte_go  <= 1'b1;
                     byte_out <= sel_byte;
                     idx      <= '0;
                     state    <= ST_SEND;
                  end
               end
               ST_LISTEN: begin
                  if (eof_pulse) state <= ST_IDLE;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R2
   nb_go_from_eod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nb_go |-> $past(eod_pulse) && busy);

   // R2
   nb_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nb_go |-> (nb_long == ($past(pol.nb_long))));

   // R5
   abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(byte_go && tx_abort));

   // R8
   brk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse |=> !busy && !responded);

   // R9
   eof_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_pulse && !brk_pulse) |=> !busy);

   // R4
   resp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(responded) |-> $past(sym_done) && !$past(arb_lost));

   // R7
   listen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (responded && busy) |-> !byte_go);

   // R10
   loss_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEND && sym_done && arb_lost && !brk_pulse && !eof_pulse)
      |=> tx_abort && !responded && !byte_go);

endmodule

// File: rtl/ifr_arb_ctrl.sv
module ifr_arb_ctrl
   import ifr_arb_pkg::*;
#(
   parameter int MAXB       = 8,
   parameter bit AND_OR_MUX = 1'b1,
   localparam int IW        = $clog2(MAXB),
   localparam int CW        = $clog2(MAXB + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eod_pulse,
   input  logic              eof_pulse,
   input  logic              brk_pulse,
   input  logic              byte_edge,
   input  logic              rsp_enable,
   input  logic [1:0]        frame_kind,
   input  logic [CW-1:0]     rsp_count,
   input  logic [8*MAXB-1:0] rsp_bytes,
   input  logic              sym_done,
   input  logic              arb_lost,
   output logic              nb_go,
   output logic              nb_long,
   output logic              byte_go,
   output logic [7:0]        byte_out,
   output logic              tx_abort,
   output logic              responded,
   output logic              busy
);

   if (MAXB < 2) begin : g_bad_maxb
      $error("ifr_arb_ctrl: MAXB must be at least 2");
   end
   if (MAXB > 256) begin : g_big_maxb
      $error("ifr_arb_ctrl: MAXB above 256 is not supported");
   end

   ifr_policy_t   pol;
   logic [IW-1:0] sel_idx;
   logic [7:0]    sel_byte;

   ifr_policy #(.MAXB(MAXB)) u_policy (
      .enable (rsp_enable),
      .kind   (frame_kind),
      .count  (rsp_count),
      .pol    (pol)
   );

   ifr_byte_sel #(.MAXB(MAXB), .AND_OR_MUX(AND_OR_MUX)) u_sel (
      .bytes (rsp_bytes),
      .idx   (sel_idx),
      .sel   (sel_byte)
   );

   ifr_fsm #(.MAXB(MAXB)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .eod_pulse (eod_pulse),
      .eof_pulse (eof_pulse),
      .brk_pulse (brk_pulse),
      .byte_edge (byte_edge),
      .sym_done  (sym_done),
      .arb_lost  (arb_lost),
      .pol       (pol),
      .count     (rsp_count),
      .sel_byte  (sel_byte),
      .sel_idx   (sel_idx),
      .nb_go     (nb_go),
      .nb_long   (nb_long),
      .byte_go   (byte_go),
      .byte_out  (byte_out),
      .tx_abort  (tx_abort),
      .responded (responded),
      .busy      (busy)
   );

   // R1
   passive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(eod_pulse && pol.valid)) |=> !nb_go && !byte_go && !tx_abort);

endmodule

// File: tb/ifr_arb_ctrl_test.sv
module ifr_arb_ctrl_test;

   localparam int MAXB = 8;
   localparam int CW   = $clog2(MAXB + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic eod_pulse = 0, eof_pulse = 0, brk_pulse = 0, byte_edge = 0;
   logic rsp_enable = 0;
   logic [1:0] frame_kind = 0;
   logic [CW-1:0] rsp_count = 0;
   logic [8*MAXB-1:0] rsp_bytes = 64'hA8A7_A6A5_A4A3_A2A1;
   logic sym_done = 0, arb_lost = 0;
   logic nb_go, nb_long, byte_go, tx_abort, responded, busy;
   logic [7:0] byte_out;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   ifr_arb_ctrl #(.MAXB(MAXB)) uut (
      .clk(clk), .rst_n(rst_n), .eod_pulse(eod_pulse), .eof_pulse(eof_pulse),
      .brk_pulse(brk_pulse), .byte_edge(byte_edge), .rsp_enable(rsp_enable),
      .frame_kind(frame_kind), .rsp_count(rsp_count), .rsp_bytes(rsp_bytes),
      .sym_done(sym_done), .arb_lost(arb_lost), .nb_go(nb_go), .nb_long(nb_long),
      .byte_go(byte_go), .byte_out(byte_out), .tx_abort(tx_abort),
      .responded(responded), .busy(busy)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive one cycle of pulses, then sample at the following falling edge
   task automatic step(input logic e, input logic f, input logic b,
                       input logic be, input logic d, input logic l);
      @(negedge clk);
      eod_pulse = e; eof_pulse = f; brk_pulse = b;
      byte_edge = be; sym_done = d; arb_lost = l;
      @(negedge clk);
      eod_pulse = 0; eof_pulse = 0; brk_pulse = 0;
      byte_edge = 0; sym_done = 0; arb_lost = 0;
   endtask

   task automatic setup(input logic en, input logic [1:0] k, input int n);
      rsp_enable = en; frame_kind = k; rsp_count = CW'(n);
   endtask

   task automatic t_reset;
      chk("R1 reset busy", busy, 0);
      chk("R1 reset nb_go", nb_go, 0);
      chk("R1 reset byte_go", byte_go, 0);
      chk("R1 reset abort", tx_abort, 0);
      chk("R1 reset responded", responded, 0);
   endtask

   task automatic t_passive;
      setup(0, 2'd1, 2);
      step(1,0,0,0,0,0); chk("R1 no enable", {nb_go, busy}, 0);
      step(0,1,0,0,0,0); chk("R1 eof passes", busy, 0);
      setup(1, 2'd1, 0);
      step(1,0,0,0,0,0); chk("R1 zero count", {nb_go, busy}, 0);
      setup(1, 2'd0, 1);
      step(1,0,0,0,0,0); chk("R1 kind none", {nb_go, busy}, 0);
      setup(1, 2'd1, 9);
      step(1,0,0,0,0,0); chk("R1 count over capacity", {nb_go, busy}, 0);
   endtask

   task automatic t_kind1_win;
      setup(1, 2'd1, 2);
      step(1,0,0,0,0,0);
      chk("R2 nb_go", nb_go, 1); chk("R2 long kind1", nb_long, 1);
      step(0,0,0,0,0,0); chk("R2 nb_go one cycle", nb_go, 0);
      step(0,0,0,0,1,0);
      chk("R3 byte_go", byte_go, 1); chk("R3 byte0", byte_out, 8'hA1);
      step(0,0,0,0,1,0);
      chk("R4 byte_go next", byte_go, 1); chk("R4 byte1", byte_out, 8'hA2);
      chk("R4 not yet responded", responded, 0);
      step(0,0,0,0,1,0);
      chk("R4 no third byte", byte_go, 0); chk("R4 responded", responded, 1);
      chk("R4 listening", busy, 1);
      step(0,1,0,0,0,0);
      chk("R9 eof idle", busy, 0); chk("R9 responded held", responded, 1);
      setup(0, 2'd1, 2);
      step(1,0,0,0,0,0); chk("R9 responded cleared by eod", responded, 0);
   endtask

   task automatic t_kind3_lose;
      setup(1, 2'd3, 3);
      step(1,0,0,0,0,0);
      chk("R2 nb_go kind3", nb_go, 1); chk("R2 short kind3", nb_long, 0);
      step(0,0,0,0,1,0); chk("R3 byte0 kind3", byte_out, 8'hA1);
      step(0,0,0,0,0,1);
      chk("R5 abort", tx_abort, 1); chk("R5 still busy", busy, 1);
      step(0,0,0,1,0,0); chk("R5 no retry on edge", {byte_go, tx_abort}, 0);
      step(0,0,0,0,1,0); chk("R5 no byte on done", byte_go, 0);
      step(0,1,0,0,0,0);
      chk("R5 eof idle", busy, 0); chk("R5 not responded", responded, 0);
   endtask

   task automatic t_kind2;
      setup(1, 2'd2, 4);
      step(1,0,0,0,0,0); chk("R2 long kind2", {nb_go, nb_long}, 2'b11);
      step(0,0,0,0,0,1); chk("R6 abort on nb loss", tx_abort, 1);
      step(0,0,0,0,1,0); chk("R6 waits for edge", byte_go, 0);
      step(0,0,0,1,0,0);
      chk("R6 retry byte_go", byte_go, 1); chk("R6 retry byte0", byte_out, 8'hA1);
      step(0,0,0,0,0,1); chk("R6 second loss abort", tx_abort, 1);
      step(0,0,0,1,0,0); chk("R6 second retry", {byte_go, byte_out}, {1'b1, 8'hA1});
      step(0,0,0,0,1,0);
      chk("R7 responded", responded, 1); chk("R7 no second byte", byte_go, 0);
      step(0,0,0,1,0,0); chk("R7 edge ignored", byte_go, 0);
      step(0,1,0,0,0,0); chk("R7 eof idle", {busy, responded}, 2'b01);
   endtask

   task automatic t_break;
      setup(1, 2'd1, 2);
      step(1,0,0,0,0,0);
      step(0,0,0,0,1,0); chk("R8 byte in flight", byte_go, 1);
      step(0,0,1,0,1,0);
      chk("R8 abort on break", tx_abort, 1); chk("R8 idle", busy, 0);
      chk("R8 no credit", {responded, byte_go}, 0);
      step(0,0,1,0,0,0); chk("R8 idle break quiet", tx_abort, 0);
   endtask

   task automatic t_collide;
      setup(1, 2'd1, 1);
      step(1,0,0,0,0,0);
      step(0,0,0,0,1,0); chk("R10 single byte sent", byte_go, 1);
      step(0,0,0,0,1,1);
      chk("R10 loss wins abort", tx_abort, 1);
      chk("R10 no credit", responded, 0); chk("R10 no load", byte_go, 0);
      step(0,1,0,0,0,0); chk("R10 eof idle", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_passive;
      t_kind1_win;
      t_kind3_lose;
      t_kind2;
      t_break;
      t_collide;
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule